// File: doc/BRIEF.md
# Non-Multiplexed Chip-Select Bus Master

This block runs a single external-bus transaction at a time on a bus with separate address and data wires. It lives in a fast internal clock domain. A one-cycle enable strobe, `bclk_en`, marks each edge of the slower bus clock, and every change on the external pins is scheduled on those strobes. A requester presents a read or write with an address, write data and a binary chip-select index. The block runs an ordered sequence and then returns a one-cycle completion pulse, together with the captured data when the access is a read. The sequence drives read/write first, then address and write data, then the strobe window, then one internal cycle of hold.

The block keeps a small bank of 4-bit wait-state counts, one per chip select, written through a configuration port. The strobe window of each access stretches by the count belonging to the selected chip select. The block measures the spacing of the bus-clock strobes as it runs. It uses that spacing to drop the output enable exactly one internal cycle before the chip select releases.

Top module: `nmx_bus_master`

## Requirements
- R1: During an access exactly one line of `bus_cs_n` is low, the line whose bit position equals `req_cs`; all other lines stay high.
- R2: The chip select stays low for exactly (2 + W) bus-clock periods. W is the 4-bit wait-state value held for that chip select. Each value resets to 0 and is replaced when `cfg_we` is high, written to entry `cfg_sel` with `cfg_ws`.
- R3: `bus_rw` (1 = read, 0 = write) carries the request's direction at least one full bus-clock period before the chip select goes low.
- R4: The new `bus_addr` appears at least one internal cycle and at most one bus-clock period before the chip select goes low. For writes, `bus_dout` carries the write data with `bus_dout_en` high from that same cycle. For reads, `bus_dout_en` stays low.
- R5: In the internal cycle after the chip select returns high, `bus_addr`, `bus_rw`, `bus_dout` and `bus_dout_en` still hold their values from the strobe window.
- R6: For reads, `bus_oe_n` goes low in the same cycle as the chip select. Once the bus-clock spacing is known, it goes high exactly one internal cycle before the chip select returns high. For writes, `bus_oe_n` never goes low.
- R7: A read captures `bus_din` in the last internal cycle in which `bus_oe_n` is low. `rsp_done` is high for exactly one cycle, the first cycle after the chip select returns high, with the captured value on `rsp_rdata`. Writes also give the pulse.
- R8: `req_valid` is taken only while `req_idle` is high. A request presented while an access is in progress is ignored and never starts a chip-select pulse.
- R9: After reset and between accesses, the idle state drives all chip selects and `bus_oe_n` high, `bus_dout_en` low, `bus_rw` high and `req_idle` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_en | input | 1 | One-cycle strobe marking each bus-clock edge |
| cfg_we | input | 1 | Wait-state bank write enable |
| cfg_sel | input | CSW | Wait-state entry to write |
| cfg_ws | input | 4 | Wait-state value to write |
| req_valid | input | 1 | Request present (taken only when idle) |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_cs | input | CSW | Binary chip-select index |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_idle | output | 1 | Controller idle and ready to take a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Captured read data |
| bus_cs_n | output | NCS | Active-low chip selects |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_rw | output | 1 | Direction, 1 = read |
| bus_addr | output | AW | External address |
| bus_dout | output | DW | External write data |
| bus_dout_en | output | 1 | Data driver enable |
| bus_din | input | DW | External read data |

## Verification
The hardest case to reach is the final bus-clock period of a read. There the output enable must drop, and the data must be captured, one internal cycle ahead of a strobe that the block cannot see coming. The stimulus runs the bus-clock strobe without a break from reset, so the block has learned the spacing before the first access. The read-side model drives `bus_din` only while the output enable is low, so a capture made at the wrong point returns a visibly wrong value. A second case is a request arriving during an access. The stimulus holds `req_valid` high for several cycles in the middle of a strobe window, drops it before completion, and then confirms that no further chip-select pulse occurs.

// File: rtl/nmx_pkg.sv
`timescale 1ns/1ps
package nmx_pkg;

    localparam int WS_W  = 4;
    localparam int LEN_W = WS_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RW,
        ST_ADDR,
        ST_STROBE,
        ST_HOLD
    } nmx_state_e;

    typedef struct packed {
        logic            rd;
        logic [WS_W-1:0] ws;
    } nmx_ctl_t;

    function automatic logic [LEN_W-1:0] strobe_len(input logic [WS_W-1:0] ws);
        return LEN_W'(ws) + LEN_W'(2);
    endfunction

endpackage

// File: rtl/nmx_phase.sv
`timescale 1ns/1ps
module nmx_phase #(
    parameter int GAP_W = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_en,
    output logic pre_edge
);
    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] per_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
            per_q <= '0;
        end else if (bclk_en) begin
            per_q <= gap_q;
            gap_q <= GAP_W'(1);
        end else if (gap_q != '1) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    assign pre_edge = !bclk_en && (per_q > GAP_W'(1)) && (gap_q == per_q - GAP_W'(1));

    // R2: the spacing counter restarts on every bus-clock strobe
    p_gap_restart_r2: assert property (@(posedge clk) disable iff (rst)
        bclk_en |=> (gap_q == GAP_W'(1)));

endmodule

// File: rtl/nmx_ws_bank.sv
`timescale 1ns/1ps
module nmx_ws_bank
    import nmx_pkg::*;
#(
    parameter int NCS    = 8,
    parameter int CSW    = 3,
    parameter int WS_RST = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [CSW-1:0]  wsel,
    input  logic [WS_W-1:0] wval,
    input  logic [CSW-1:0]  rsel,
    output logic [WS_W-1:0] rval
);
    logic [WS_W-1:0] ws_q [NCS];

    for (genvar i = 0; i < NCS; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                ws_q[i] <= WS_W'(WS_RST);
            end else if (we && (wsel == CSW'(i))) begin
                ws_q[i] <= wval;
            end
        end
    end

    always_comb begin
        rval = '0;
        for (int i = 0; i < NCS; i++) begin
            if (rsel == CSW'(i)) rval = ws_q[i];
        end
    end

    // R2: a configuration write lands in the addressed entry
    p_cfg_write_r2: assert property (@(posedge clk) disable iff (rst)
        (we && (int'(wsel) < NCS)) |=> (ws_q[$past(wsel)] == $past(wval)));

endmodule

// File: rtl/nmx_seq.sv
`timescale 1ns/1ps
module nmx_seq
    import nmx_pkg::*;
#(
    parameter int NCS = 8,
    parameter int CSW = 3,
    parameter int AW  = 20,
    parameter int DW  = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bclk_en,
    input  logic            pre_edge,
    input  logic            req_valid,
    input  logic            req_rd,
    input  logic [CSW-1:0]  req_cs,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [WS_W-1:0] req_ws,
    output logic            idle,
    output logic            done,
    output logic [DW-1:0]   rdata,
    output logic [NCS-1:0]  cs_n,
    output logic            oe_n,
    output logic            rw,
    output logic [AW-1:0]   addr,
    output logic [DW-1:0]   dout,
    output logic            dout_en,
    input  logic [DW-1:0]   din
);
    nmx_state_e       st_q;
    nmx_ctl_t         ctl_q;
    logic [CSW-1:0]   cs_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic [LEN_W-1:0] len_q;
    logic [NCS-1:0]   cs_dec;

    logic [NCS-1:0]   cs_n_q;
    logic             oe_n_q;
    logic             rw_q;
    logic [AW-1:0]    addr_o;
    logic [DW-1:0]    dout_o;
    logic             den_q;
    logic             done_q;
    logic [DW-1:0]    rdata_q;

    for (genvar i = 0; i < NCS; i++) begin : g_dec
        assign cs_dec[i] = (cs_q == CSW'(i));
    end

    wire last_period = (len_q == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            ctl_q   <= '0;
            cs_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            len_q   <= '0;
            cs_n_q  <= '1;
            oe_n_q  <= 1'b1;
            rw_q    <= 1'b1;
            addr_o  <= '0;
            dout_o  <= '0;
            den_q   <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        ctl_q   <= '{rd: req_rd, ws: req_ws};
                        cs_q    <= req_cs;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        rw_q    <= req_rd;
                        st_q    <= ST_RW;
                    end
                end
                ST_RW: begin
                    if (bclk_en) begin
                        addr_o <= addr_q;
                        dout_o <= wdata_q;
                        den_q  <= !ctl_q.rd;
                        st_q   <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (bclk_en) begin
                        cs_n_q <= ~cs_dec;
                        oe_n_q <= !ctl_q.rd;
                        len_q  <= strobe_len(ctl_q.ws);
                        st_q   <= ST_STROBE;
                    end
                end
                ST_STROBE: begin
                    if (bclk_en) begin
                        if (last_period) begin
                            cs_n_q <= '1;
                            oe_n_q <= 1'b1;
                            done_q <= 1'b1;
                            st_q   <= ST_HOLD;
                            if (ctl_q.rd && !oe_n_q) rdata_q <= din;
                        end else begin
                            len_q <= len_q - LEN_W'(1);
                        end
                    end else if (pre_edge && last_period && ctl_q.rd) begin
                        oe_n_q  <= 1'b1;
                        rdata_q <= din;
                    end
                end
                ST_HOLD: begin
                    den_q <= 1'b0;
                    rw_q  <= 1'b1;
                    st_q  <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign idle    = (st_q == ST_IDLE);
    assign done    = done_q;
    assign rdata   = rdata_q;
    assign cs_n    = cs_n_q;
    assign oe_n    = oe_n_q;
    assign rw      = rw_q;
    assign addr    = addr_o;
    assign dout    = dout_o;
    assign dout_en = den_q;

    wire cs_act = ~&cs_n_q;

    // R1: never more than one chip select low
    p_cs_single_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n_q) <= 1);

    // R5: address and direction frozen through the strobe and the hold cycle
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (cs_act || $past(cs_act)) |-> ($stable(addr_o) && $stable(rw_q)));

    // R6: output enable only inside a read strobe
    p_oe_read_only_r6: assert property (@(posedge clk) disable iff (rst)
        !oe_n_q |-> (ctl_q.rd && cs_act));

    // R4: data driver only on writes
    p_dout_write_r4: assert property (@(posedge clk) disable iff (rst)
        den_q |-> !rw_q);

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R8: a latched request is not disturbed while busy
    p_busy_latch_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE) |=> ($stable(addr_q) && $stable(cs_q) && $stable(ctl_q)));

endmodule

// File: rtl/nmx_bus_master.sv
`timescale 1ns/1ps
module nmx_bus_master
    import nmx_pkg::*;
#(
    parameter int NCS    = 8,
    parameter int CSW    = (NCS > 1) ? $clog2(NCS) : 1,
    parameter int AW     = 20,
    parameter int DW     = 16,
    parameter int GAP_W  = 6,
    parameter int WS_RST = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bclk_en,
    input  logic            cfg_we,
    input  logic [CSW-1:0]  cfg_sel,
    input  logic [WS_W-1:0] cfg_ws,
    input  logic            req_valid,
    input  logic            req_rd,
    input  logic [CSW-1:0]  req_cs,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            req_idle,
    output logic            rsp_done,
    output logic [DW-1:0]   rsp_rdata,
    output logic [NCS-1:0]  bus_cs_n,
    output logic            bus_oe_n,
    output logic            bus_rw,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_dout,
    output logic            bus_dout_en,
    input  logic [DW-1:0]   bus_din
);
    logic [WS_W-1:0] sel_ws;
    logic            pre_edge;

    nmx_ws_bank #(.NCS(NCS), .CSW(CSW), .WS_RST(WS_RST)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .wsel (cfg_sel),
        .wval (cfg_ws),
        .rsel (req_cs),
        .rval (sel_ws)
    );

    nmx_phase #(.GAP_W(GAP_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .bclk_en  (bclk_en),
        .pre_edge (pre_edge)
    );

    nmx_seq #(.NCS(NCS), .CSW(CSW), .AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .bclk_en   (bclk_en),
        .pre_edge  (pre_edge),
        .req_valid (req_valid),
        .req_rd    (req_rd),
        .req_cs    (req_cs),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ws    (sel_ws),
        .idle      (req_idle),
        .done      (rsp_done),
        .rdata     (rsp_rdata),
        .cs_n      (bus_cs_n),
        .oe_n      (bus_oe_n),
        .rw        (bus_rw),
        .addr      (bus_addr),
        .dout      (bus_dout),
        .dout_en   (bus_dout_en),
        .din       (bus_din)
    );

    // R9: idle means a quiet bus
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        req_idle |-> ((&bus_cs_n) && bus_oe_n && !bus_dout_en && bus_rw));

endmodule

// File: tb/nmx_bus_master_tb.sv
`timescale 1ns/1ps
module nmx_bus_master_tb;

    localparam int NCS   = 8;
    localparam int AW    = 20;
    localparam int DW    = 16;
    localparam int RATIO = 4;
    localparam logic [DW-1:0] DIN_KEY = 16'h5A3C;

    typedef struct packed {
        logic          rd;
        logic [2:0]    cs;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 3'd0, 20'h01234, 16'hBEEF},
        '{1'b1, 3'd1, 20'h0ABCD, 16'h0000},
        '{1'b0, 3'd2, 20'hF0F0F, 16'h1357},
        '{1'b1, 3'd3, 20'h11111, 16'h0000},
        '{1'b1, 3'd4, 20'h7FFFF, 16'h0000},
        '{1'b0, 3'd5, 20'h80000, 16'hFFFF},
        '{1'b1, 3'd6, 20'h2468A, 16'h0000},
        '{1'b1, 3'd7, 20'h00005, 16'h0000}
    };

    logic            clk = 1'b0;
    logic            rst;
    logic            bclk_en;
    logic            cfg_we;
    logic [2:0]      cfg_sel;
    logic [3:0]      cfg_ws;
    logic            req_valid;
    logic            req_rd;
    logic [2:0]      req_cs;
    logic [AW-1:0]   req_addr;
    logic [DW-1:0]   req_wdata;
    logic            req_idle;
    logic            rsp_done;
    logic [DW-1:0]   rsp_rdata;
    logic [NCS-1:0]  bus_cs_n;
    logic            bus_oe_n;
    logic            bus_rw;
    logic [AW-1:0]   bus_addr;
    logic [DW-1:0]   bus_dout;
    logic            bus_dout_en;
    logic [DW-1:0]   bus_din;

    always #2.5 clk = ~clk;

    assign bus_din = bus_oe_n ? 16'hDEAD : (bus_addr[DW-1:0] ^ DIN_KEY);

    nmx_bus_master u_dut (
        .clk(clk), .rst(rst), .bclk_en(bclk_en),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_ws(cfg_ws),
        .req_valid(req_valid), .req_rd(req_rd), .req_cs(req_cs),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_idle(req_idle), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_rw(bus_rw),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .bus_din(bus_din)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected model state
    logic [3:0]    ws_exp [NCS];
    logic          exp_rd;
    int            exp_cs;
    logic [AW-1:0] exp_addr;
    logic [DW-1:0] exp_wdata;
    bit            done_seen;
    int            events;

    // monitor state
    bit            mon_en = 0;
    bit            prev_act, prev_done, post_hold;
    int            addr_age, rw_age, len, oe_low;
    logic [AW-1:0] last_addr;
    logic          last_rw, last_oe, pen_oe;
    logic [AW-1:0] rec_addr;
    logic          rec_rw, rec_den;
    logic [DW-1:0] rec_dout;

    initial begin
        bclk_en = 1'b0;
        forever begin
            repeat (RATIO - 1) @(negedge clk);
            bclk_en = 1'b1;
            @(negedge clk);
            bclk_en = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (mon_en) begin
            logic cs_act;
            cs_act = ~&bus_cs_n;
            if (bus_addr == last_addr) addr_age++; else addr_age = 0;
            if (bus_rw == last_rw) rw_age++; else rw_age = 0;
            last_addr = bus_addr;
            last_rw   = bus_rw;

            if (post_hold) begin
                chk(!rsp_done, "R7 done lasts one cycle", rsp_done, 0);
                chk(req_idle && (&bus_cs_n) && bus_oe_n && !bus_dout_en && bus_rw,
                    "R9 idle outputs after access",
                    {req_idle, bus_cs_n, bus_oe_n, bus_dout_en, bus_rw}, {1'b1, 8'hFF, 1'b1, 1'b0, 1'b1});
                post_hold = 0;
            end

            if (rsp_done && prev_done) chk(0, "R7 done longer than one cycle", 1, 0);

            if (cs_act && !prev_act) begin
                events++;
                chk(bus_cs_n == ~(8'b1 << exp_cs), "R1 chip-select line", bus_cs_n, ~(8'b1 << exp_cs));
                chk(bus_rw == exp_rd && rw_age >= RATIO, "R3 direction lead", rw_age, RATIO);
                chk(bus_addr == exp_addr && addr_age >= 1 && addr_age <= RATIO,
                    "R4 address lead window", {bus_addr, 8'(addr_age)}, {exp_addr, 8'(RATIO)});
                chk(bus_dout_en == !exp_rd && (exp_rd || (bus_dout == exp_wdata && addr_age >= 1)),
                    "R4 write data driven", {bus_dout_en, bus_dout}, {!exp_rd, exp_wdata});
                chk(bus_oe_n == !exp_rd, "R6 output enable at strobe start", bus_oe_n, !exp_rd);
                rec_addr = bus_addr; rec_rw = bus_rw; rec_den = bus_dout_en; rec_dout = bus_dout;
                len = 1;
                oe_low = bus_oe_n ? 0 : 1;
                pen_oe = 1'b1;
                last_oe = bus_oe_n;
            end else if (cs_act) begin
                len++;
                if (!bus_oe_n) oe_low++;
                pen_oe = last_oe;
                last_oe = bus_oe_n;
            end else if (prev_act) begin
                chk(len == (2 + int'(ws_exp[exp_cs])) * RATIO, "R2 strobe width",
                    len, (2 + int'(ws_exp[exp_cs])) * RATIO);
                chk(bus_addr == rec_addr && bus_rw == rec_rw && bus_dout_en == rec_den && bus_dout == rec_dout,
                    "R5 hold after release", {bus_addr, bus_rw, bus_dout_en, bus_dout},
                    {rec_addr, rec_rw, rec_den, rec_dout});
                chk(rsp_done, "R7 done after release", rsp_done, 1);
                if (exp_rd) begin
                    chk(last_oe && !pen_oe && oe_low == len - 1, "R6 early output-enable release",
                        oe_low, len - 1);
                    chk(rsp_rdata == (exp_addr[DW-1:0] ^ DIN_KEY), "R7 read data",
                        rsp_rdata, exp_addr[DW-1:0] ^ DIN_KEY);
                end else begin
                    chk(oe_low == 0, "R6 no output enable on write", oe_low, 0);
                end
                done_seen = 1;
                post_hold = 1;
            end
            prev_act  = cs_act;
            prev_done = rsp_done;
        end
    end

    task automatic cfg_write(input int sel, input logic [3:0] ws);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_ws = ws;
        @(negedge clk);
        cfg_we = 1'b0;
        ws_exp[sel] = ws;
    endtask

    task automatic access(input logic rd, input int cs, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int w;
        w = 0;
        while (!req_idle && w < 500) begin @(negedge clk); w++; end
        exp_rd = rd; exp_cs = cs; exp_addr = a; exp_wdata = d;
        done_seen = 0;
        req_rd = rd; req_cs = 3'(cs); req_addr = a; req_wdata = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        w = 0;
        while (!done_seen && w < 500) begin @(negedge clk); w++; end
        chk(done_seen, "R7 access completes", done_seen, 1);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #750000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int ev0;
        rst = 1'b1;
        cfg_we = 0; cfg_sel = 0; cfg_ws = 0;
        req_valid = 0; req_rd = 0; req_cs = 0; req_addr = 0; req_wdata = 0;
        for (int i = 0; i < NCS; i++) ws_exp[i] = 4'd0;
        events = 0; done_seen = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk(req_idle && (&bus_cs_n) && bus_oe_n && !bus_dout_en && bus_rw && !rsp_done,
            "R9 reset state", {req_idle, bus_cs_n, bus_oe_n, bus_dout_en, bus_rw, rsp_done},
            {1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0});
        last_addr = bus_addr; last_rw = bus_rw;
        addr_age = 0; rw_age = 0; prev_act = 0; prev_done = 0; post_hold = 0;
        mon_en = 1;

        // R2: program every entry except 7, which keeps its reset value
        for (int i = 0; i < NCS - 1; i++) cfg_write(i, 4'((i * 5) % 16));
        repeat (12) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            access(VECS[v].rd, int'(VECS[v].cs), VECS[v].addr, VECS[v].wdata);
        end

        // R2: minimum and maximum wait-state values, both directions
        cfg_write(0, 4'd0);
        access(1'b1, 0, 20'h3C3C3, 16'h0);
        cfg_write(3, 4'd15);
        access(1'b0, 3, 20'h55AA5, 16'hA5A5);
        // R2: rewriting one entry leaves others untouched
        access(1'b0, 1, 20'h0F00F, 16'h4242);

        // R8: request while busy is ignored
        ev0 = events;
        exp_rd = 1'b1; exp_cs = 2; exp_addr = 20'h12121; exp_wdata = '0;
        done_seen = 0;
        req_rd = 1'b1; req_cs = 3'd2; req_addr = 20'h12121; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (14) @(negedge clk);
        chk(!req_idle, "R8 busy during access", req_idle, 0);
        req_rd = 1'b0; req_cs = 3'd5; req_addr = 20'h99999; req_wdata = 16'h7777; req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        for (int w = 0; w < 500 && !done_seen; w++) @(negedge clk);
        chk(done_seen, "R8 first access completes", done_seen, 1);
        repeat (120) @(negedge clk);
        chk(events == ev0 + 1, "R8 ignored request made no strobe", events - ev0, 1);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule